// File: doc/BRIEF.md
# Channel Wake Event Reporter

This block keeps the wake events of a set of communication channels and tells software about them through an interrupt line and two readable registers. Each channel can receive three kinds of event: it has become readable, it has become writable, or its far end has closed. Software can ask to be woken when a channel becomes readable or writable by arming that channel. A readable or writable event is kept only if the matching arm is already set. A closed event is always kept. The interrupt line stays high while any channel holds a kept event.

When the interrupt fires, software empties the list of events in a loop. It reads the channel register to get the identifier of the next channel with kept events, then reads the wake register to get that channel's event bits. It stops when a channel read returns zero. Channel `i` of the table has identifier `i+1`, so zero is never a valid channel. Reading the wake register retires the events it returns, together with the arms those events used up.

The read port is a register strobe and not a stream. It has no back-pressure because a register read cannot be stalled: `rd_en_i` is accepted in every cycle, and the answer appears on `rd_data_o` after the next clock edge. It then holds until the next accepted read.

Top module: `wake_list_reader`

## Requirements
- R1: After reset, `irq_o` is low, `rd_data_o` is zero, and a channel read returns zero.
- R2: `irq_o` is high in every cycle where at least one channel holds a kept event, and low otherwise. An event strobed at a clock edge is counted from that edge onward.
- R3: A channel read (`rd_sel_i`=0) returns `i+1`, where `i` is the lowest table index with a kept event. The list is therefore drained in ascending table order.
- R4: A channel read while no channel holds an event returns zero.
- R5: A wake read (`rd_sel_i`=1) that follows a nonzero channel read returns that channel's kept events. Bit 0 is readable, bit 1 is writable and bit 2 is closed; all higher bits are zero. The read clears those events and clears the read or write arm of each readable or writable bit it returned.
- R6: A readable or writable strobe on a channel whose matching arm was not set before that cycle is ignored. It leaves no event and does not raise `irq_o`.
- R7: A closed strobe is kept with no arm at all.
- R8: An event that arrives during a drain is merged into the kept bits and reported by a later read. This holds even when it arrives on the channel being retired in the same cycle as its wake read.
- R9: A wake read with no channel selected returns zero and clears nothing. This covers a wake read after reset, after a zero channel read, or after a previous wake read.
- R10: `rd_data_o` changes only on the clock edge after an accepted read and holds its value at all other times.
- R11: An arm that no returned event used up stays set. For example, a write arm survives the retirement of a readable event on the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_readable_i | input | NUM_CH | Per-channel readable strobe |
| evt_writable_i | input | NUM_CH | Per-channel writable strobe |
| evt_closed_i | input | NUM_CH | Per-channel peer-closed strobe |
| arm_rd_i | input | NUM_CH | Per-channel request to be woken on readable |
| arm_wr_i | input | NUM_CH | Per-channel request to be woken on writable |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | 0 selects the channel register, 1 the wake register |
| rd_data_o | output | DATA_W | Read data, valid from the edge after the strobe |
| irq_o | output | 1 | Level interrupt: some channel holds an event |

## Verification
The hardest cases to reach are events that collide with the drain itself. Examples are a closed strobe on the channel being retired in the same cycle as its wake read, and a strobe on a lower channel between a channel read and its wake read. The stimulus reaches these by driving event strobes in the same cycle as read strobes. A behavioural model tracks every kept bit and arm, so each merge shows up on the following reads. The arming order is also exercised: readable and writable strobes are sent to unarmed, consumed and still-armed channels, and the results are observed through later channel reads.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned WB_READ   = 0;
  localparam int unsigned WB_WRITE  = 1;
  localparam int unsigned WB_CLOSED = 2;
  localparam int unsigned WAKE_W    = 3;

  typedef logic [WAKE_W-1:0] wake_mask_t;

  typedef enum logic {
    SEL_CHAN = 1'b0,
    SEL_MASK = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/wake_slot.sv
module wake_slot
  import wake_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_rd_i,
  input  logic       evt_wr_i,
  input  logic       evt_cl_i,
  input  logic       arm_rd_i,
  input  logic       arm_wr_i,
  input  logic       consume_i,
  output wake_mask_t pend_o,
  output logic       armed_rd_o,
  output logic       armed_wr_o
);
  wake_mask_t pend_q;
  wake_mask_t arrive;
  logic       arm_rd_q;
  logic       arm_wr_q;

  // Gate readable/writable at arrival on arms held before this cycle.
  always_comb begin
    arrive            = '0;
    arrive[WB_READ]   = evt_rd_i & arm_rd_q;
    arrive[WB_WRITE]  = evt_wr_i & arm_wr_q;
    arrive[WB_CLOSED] = evt_cl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      arm_rd_q <= 1'b0;
      arm_wr_q <= 1'b0;
    end else begin
      // Retire the snapshot that was reported; keep same-cycle arrivals.
      pend_q   <= consume_i ? arrive : (pend_q | arrive);
      arm_rd_q <= arm_rd_i | (arm_rd_q & ~(consume_i & pend_q[WB_READ]));
      arm_wr_q <= arm_wr_i | (arm_wr_q & ~(consume_i & pend_q[WB_WRITE]));
    end
  end

  assign pend_o     = pend_q;
  assign armed_rd_o = arm_rd_q;
  assign armed_wr_o = arm_wr_q;
endmodule

// File: rtl/wake_scan.sv
module wake_scan #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] busy_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  // Lowest busy index wins: walk downward so later assignments override.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (busy_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wake_list_reader.sv
module wake_list_reader
  import wake_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_readable_i,
  input  logic [NUM_CH-1:0] evt_writable_i,
  input  logic [NUM_CH-1:0] evt_closed_i,
  input  logic [NUM_CH-1:0] arm_rd_i,
  input  logic [NUM_CH-1:0] arm_wr_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  wake_mask_t        pend_w [NUM_CH];
  logic [NUM_CH-1:0] busy;
  logic [NUM_CH-1:0] consume;
  logic [NUM_CH-1:0] pend_rd_vec;
  logic [NUM_CH-1:0] arm_rd_vec;
  logic [NUM_CH-1:0] pend_wr_vec;
  logic [NUM_CH-1:0] arm_wr_vec;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              sel_valid_q;
  logic [IDX_W-1:0]  sel_idx_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              chan_rd;
  logic              mask_rd;

  assign chan_rd = rd_en_i & (rd_sel_e'(rd_sel_i) == SEL_CHAN);
  assign mask_rd = rd_en_i & (rd_sel_e'(rd_sel_i) == SEL_MASK);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    assign consume[g] = mask_rd & sel_valid_q & (sel_idx_q == IDX_W'(g));

    wake_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_rd_i   (evt_readable_i[g]),
      .evt_wr_i   (evt_writable_i[g]),
      .evt_cl_i   (evt_closed_i[g]),
      .arm_rd_i   (arm_rd_i[g]),
      .arm_wr_i   (arm_wr_i[g]),
      .consume_i  (consume[g]),
      .pend_o     (pend_w[g]),
      .armed_rd_o (arm_rd_vec[g]),
      .armed_wr_o (arm_wr_vec[g])
    );

    assign busy[g]        = |pend_w[g];
    assign pend_rd_vec[g] = pend_w[g][WB_READ];
    assign pend_wr_vec[g] = pend_w[g][WB_WRITE];
  end

  wake_scan #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_scan (
    .busy_i (busy),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
      rd_data_q   <= '0;
    end else if (chan_rd) begin
      sel_valid_q <= hit;
      sel_idx_q   <= hit_idx;
      rd_data_q   <= hit ? (DATA_W'(hit_idx) + DATA_W'(1)) : '0;
    end else if (mask_rd) begin
      sel_valid_q <= 1'b0;
      rd_data_q   <= sel_valid_q ? DATA_W'(pend_w[sel_idx_q]) : '0;
    end
  end

  assign rd_data_o = rd_data_q;
  assign irq_o     = |busy;
endmodule

// File: rtl/wake_list_reader_chk.sv
module wake_list_reader_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              rd_en_i,
  input logic              rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_CH-1:0] evt_closed_i,
  input logic [NUM_CH-1:0] pend_rd_vec,
  input logic [NUM_CH-1:0] arm_rd_vec,
  input logic [NUM_CH-1:0] pend_wr_vec,
  input logic [NUM_CH-1:0] arm_wr_vec
);
  p_closed_raises_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_closed_i) |=> irq_o);

  p_empty_list_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i && !irq_o) |=> (rd_data_o == '0));

  p_pending_nonzero_id_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i && irq_o) |=> (rd_data_o != '0));

  p_mask_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i) |=> (rd_data_o[DATA_W-1:3] == '0));

  p_data_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  p_read_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_rd_vec & ~$past(pend_rd_vec) & ~$past(arm_rd_vec)) == '0));

  p_write_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_wr_vec & ~$past(pend_wr_vec) & ~$past(arm_wr_vec)) == '0));
endmodule

bind wake_list_reader wake_list_reader_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .rd_en_i      (rd_en_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .evt_closed_i (evt_closed_i),
  .pend_rd_vec  (pend_rd_vec),
  .arm_rd_vec   (arm_rd_vec),
  .pend_wr_vec  (pend_wr_vec),
  .arm_wr_vec   (arm_wr_vec)
);

// File: tb/wake_list_reader_tb.sv
module wake_list_reader_tb_top;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] evt_rd = '0, evt_wr = '0, evt_cl = '0, arm_r = '0, arm_w = '0;
  logic              rd_en = 1'b0;
  logic              rd_sel = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  wake_list_reader #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_readable_i(evt_rd), .evt_writable_i(evt_wr), .evt_closed_i(evt_cl),
    .arm_rd_i(arm_r), .arm_wr_i(arm_w),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // Behavioural reference model
  int          m_pend [NUM_CH];
  bit          m_ar   [NUM_CH];
  bit          m_aw   [NUM_CH];
  int          o_pend [NUM_CH];
  bit          o_ar   [NUM_CH];
  bit          o_aw   [NUM_CH];
  bit          m_cons [NUM_CH];
  bit          m_sv = 0;
  int          m_si = 0;
  logic [31:0] m_rd = '0;

  initial for (int i = 0; i < NUM_CH; i++) begin
    m_pend[i] = 0; m_ar[i] = 0; m_aw[i] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin m_pend[i] = 0; m_ar[i] = 0; m_aw[i] = 0; end
      m_sv = 0; m_si = 0; m_rd = '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        o_pend[i] = m_pend[i]; o_ar[i] = m_ar[i]; o_aw[i] = m_aw[i]; m_cons[i] = 0;
      end
      if (rd_en && !rd_sel) begin
        m_sv = 0; m_rd = '0;
        for (int i = NUM_CH - 1; i >= 0; i--)
          if (o_pend[i] != 0) begin m_sv = 1; m_si = i; m_rd = i + 1; end
      end else if (rd_en && rd_sel) begin
        if (m_sv) begin m_rd = o_pend[m_si]; m_cons[m_si] = 1; end
        else m_rd = '0;
        m_sv = 0;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        m_pend[i] = m_cons[i] ? 0 : o_pend[i];
        if (evt_rd[i] && o_ar[i]) m_pend[i] |= 1;
        if (evt_wr[i] && o_aw[i]) m_pend[i] |= 2;
        if (evt_cl[i]) m_pend[i] |= 4;
        m_ar[i] = arm_r[i] || (o_ar[i] && !(m_cons[i] && o_pend[i][0]));
        m_aw[i] = arm_w[i] || (o_aw[i] && !(m_cons[i] && o_pend[i][1]));
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit any;
      any = 0;
      for (int i = 0; i < NUM_CH; i++) if (m_pend[i] != 0) any = 1;
      chk("R2 irq vs model", 32'(irq), 32'(any));
      chk("R10 rd_data vs model", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic events(input logic [NUM_CH-1:0] r, w, c, ar, aw);
    @(negedge clk);
    evt_rd = r; evt_wr = w; evt_cl = c; arm_r = ar; arm_w = aw;
    @(negedge clk);
    evt_rd = '0; evt_wr = '0; evt_cl = '0; arm_r = '0; arm_w = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 rd_data after reset", rd_data, 0);
    rd(0, got); chk("R1 channel read after reset", got, 0);
    rd(1, got); chk("R9 wake read with no selection", got, 0);

    // R7: closed with no arm
    events('0, '0, 8'h04, '0, '0);
    chk("R7 closed raises irq", 32'(irq), 1);
    rd(0, got); chk("R3 closed ch2 id", got, 3);
    rd(1, got); chk("R5 closed mask", got, 4);
    rd(0, got); chk("R4 list empty", got, 0);
    chk("R2 irq low when empty", 32'(irq), 0);

    // R6: readable with no arm is ignored
    events(8'h02, 8'h02, '0, '0, '0);
    chk("R6 unarmed strobes keep irq low", 32'(irq), 0);
    rd(0, got); chk("R6 unarmed strobes leave no event", got, 0);

    // R5/R11: arms consumed selectively
    events('0, '0, '0, 8'h02, 8'h22);
    events(8'h02, '0, '0, '0, '0);
    rd(0, got); chk("R3 readable ch1 id", got, 2);
    rd(1, got); chk("R5 readable mask", got, 1);
    events('0, 8'h02, '0, '0, '0);
    rd(0, got); chk("R11 write arm survived", got, 2);
    rd(1, got); chk("R11 writable mask", got, 2);
    events(8'h02, 8'h02, '0, '0, '0);
    rd(0, got); chk("R5 consumed arms drop new strobes", got, 0);

    // R3: ascending order over several channels
    events('0, '0, '0, 8'h41, '0);
    events(8'h41, 8'h20, 8'h80, '0, '0);
    rd(0, got); chk("R3 order first", got, 1);
    rd(1, got); chk("R5 ch0 mask", got, 1);
    rd(0, got); chk("R3 order second", got, 6);
    rd(1, got); chk("R5 ch5 mask", got, 2);
    rd(0, got); chk("R3 order third", got, 7);
    rd(1, got); chk("R5 ch6 mask", got, 1);
    rd(0, got); chk("R3 order fourth", got, 8);
    rd(1, got); chk("R5 ch7 mask", got, 4);
    rd(0, got); chk("R4 drained", got, 0);

    // R8: merge during drain
    events('0, '0, 8'h08, '0, '0);
    rd(0, got); chk("R8 select ch3", got, 4);
    events('0, '0, 8'h02, '0, '0);
    rd(1, got); chk("R8 ch3 mask", got, 4);
    rd(0, got); chk("R8 late lower channel reported", got, 2);
    rd(1, got); chk("R8 late mask", got, 4);
    events('0, '0, 8'h08, '0, '0);
    rd(0, got); chk("R8 select ch3 again", got, 4);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 1'b1; evt_cl = 8'h08;
    @(negedge clk);
    rd_en = 1'b0; evt_cl = '0;
    chk("R8 mask with same-cycle close", rd_data, 4);
    chk("R8 same-cycle close still pending", 32'(irq), 1);
    rd(0, got); chk("R8 ch3 reported again", got, 4);
    rd(1, got); chk("R8 second mask", got, 4);
    rd(0, got); chk("R4 drained after merge", got, 0);

    // R9: wake read with nothing selected clears nothing
    events('0, '0, 8'h01, '0, '0);
    rd(1, got); chk("R9 unselected wake read", got, 0);
    chk("R9 event kept", 32'(irq), 1);
    rd(0, got); chk("R9 ch0 still listed", got, 1);
    rd(1, got); chk("R9 ch0 mask", got, 4);
    repeat (3) @(negedge clk);
    chk("R10 data holds while idle", rd_data, 4);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule